// File: doc/BRIEF.md
# Synchronous Rectifier Edge Modulator

This block produces the gate waveforms for two synchronous rectifiers. A free-running phase counter steps through each switching period. Each rectifier gate is high between a turn-on edge and a turn-off edge. That gives four edge times per period. Each edge starts from a nominal time supplied by the PWM timebase.

Each edge can be moved by a signed balance-modulation value. The move only happens if that edge is opted in, and a per-edge direction bit selects later or earlier. All four edges are then pulled earlier by one common driver-delay code, to make up for gate-driver propagation. The result is clamped inside the period.

Period length, nominal edges, modulation and configuration are all sampled together at the boundary between two periods. A change in the middle of a period cannot glitch a gate.

Top module: `sr_edge_mod`

## Requirements
- R1: `phase` counts 0, 1, …, P-1 and then returns to 0. P is the `period` input sampled at the start of that period. A sampled `period` below 2 runs as a period of 2.
- R2: In the cycle where `phase` equals k, a gate is high exactly when its turn-on time ≤ k < its turn-off time. A gate whose turn-on time is not below its turn-off time stays low for the whole period.
- R3: `edge_cfg` holds an enable/direction pair for each edge. Bits 7/6 serve the SR1 turn-on edge, bits 5/4 the SR1 turn-off edge, bits 3/2 the SR2 turn-on edge and bits 1/0 the SR2 turn-off edge. The higher bit of each pair is the enable.
- R4: While an edge's enable bit is 0, `bal_mod` has no effect on that edge.
- R5: For an enabled edge, direction bit 0 adds `bal_mod` (signed, two's complement) to the edge time, and direction bit 1 subtracts it.
- R6: The low six bits of `dly_cfg` form an unsigned code. Every edge time is reduced by that many clock ticks, where one tick is 5 ns at a 200 MHz clock.
- R7: Bits 7:6 of `dly_cfg` have no effect on the gates.
- R8: Each edge time is nominal − delay ± modulation, clamped to the range 0 … P-1.
- R9: Changes to any input other than reset during a period first show in the following period.
- R10: While `rst_n` is low, `phase` is 0 and both gates are low. The first period begins on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, 200 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | PW | Switching period length in clock ticks |
| nom_sr1_on | input | PW | Nominal SR1 turn-on time |
| nom_sr1_off | input | PW | Nominal SR1 turn-off time |
| nom_sr2_on | input | PW | Nominal SR2 turn-on time |
| nom_sr2_off | input | PW | Nominal SR2 turn-off time |
| bal_mod | input | MW | Signed balance-modulation value |
| edge_cfg | input | 8 | Per-edge enable/direction pairs |
| dly_cfg | input | 8 | Driver-delay code in bits 5:0; bits 7:6 unused |
| phase | output | PW | Position inside the current period |
| sr1_gate | output | 1 | Rectifier 1 gate |
| sr2_gate | output | 1 | Rectifier 2 gate |

## Verification
The hardest case to reach is an input change in the middle of a period. The new settings must not touch the running period, yet they must fully take over in the next one. The stimulus tracks `phase` and drives a second configuration partway through a checked period. It compares every cycle against the old edges until the wrap, then against the new edges for the whole following period. Clamping at both ends is reached by mixing large delay codes with large positive and negative modulation on edges placed near 0 and near P-1.

// File: rtl/sr_mod_pkg.sv
package sr_mod_pkg;

    localparam int NUM_EDGES = 4;
    localparam int DLY_BITS  = 6;

    // Edge index order; the cfg bit pair of edge i is [7-2i : 6-2i]
    typedef enum logic [1:0] {
        EDGE_SR1_ON  = 2'd0,
        EDGE_SR1_OFF = 2'd1,
        EDGE_SR2_ON  = 2'd2,
        EDGE_SR2_OFF = 2'd3
    } edge_idx_e;

    typedef struct packed {
        logic en;   // modulation applied
        logic sgn;  // 1: subtract modulation (earlier)
    } edge_ctl_t;

    function automatic edge_ctl_t ctl_of(input logic [7:0] cfg, input int idx);
        edge_ctl_t c;
        c.en  = cfg[7 - 2*idx];
        c.sgn = cfg[6 - 2*idx];
        return c;
    endfunction

endpackage

// File: rtl/sr_edge_calc.sv
module sr_edge_calc
    import sr_mod_pkg::*;
#(
    parameter int PW = 10,
    parameter int MW = 8
) (
    input  logic [PW-1:0]       nom,
    input  logic [PW-1:0]       per_eff,
    input  logic signed [MW-1:0] mod_val,
    input  edge_ctl_t           ctl,
    input  logic [DLY_BITS-1:0] dly,
    output logic [PW-1:0]       edge_t
);
    localparam int AW = PW + MW + 3;

    logic signed [AW-1:0] base_s, dly_s, mod_s, shift_s, sum_s, hi_s;

    always_comb begin
        base_s  = signed'({{(AW-PW){1'b0}}, nom});
        dly_s   = signed'({{(AW-DLY_BITS){1'b0}}, dly});
        mod_s   = signed'({{(AW-MW){mod_val[MW-1]}}, mod_val});
        hi_s    = signed'({{(AW-PW){1'b0}}, per_eff}) - signed'(AW'(1));
        if (!ctl.en) begin
            shift_s = '0;
        end else if (ctl.sgn) begin
            shift_s = -mod_s;
        end else begin
            shift_s = mod_s;
        end
        sum_s = base_s - dly_s + shift_s;
        if (sum_s < 0) begin
            edge_t = '0;
        end else if (sum_s > hi_s) begin
            edge_t = hi_s[PW-1:0];
        end else begin
            edge_t = sum_s[PW-1:0];
        end
    end

endmodule

// File: rtl/sr_gate_win.sv
module sr_gate_win #(
    parameter int PW = 10
) (
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] t_on,
    input  logic [PW-1:0] t_off,
    output logic          gate
);
    always_comb begin
        gate = (pos >= t_on) && (pos < t_off);
    end
endmodule

// File: rtl/sr_edge_mod.sv
module sr_edge_mod
    import sr_mod_pkg::*;
#(
    parameter int PW = 10,
    parameter int MW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        period,
    input  logic [PW-1:0]        nom_sr1_on,
    input  logic [PW-1:0]        nom_sr1_off,
    input  logic [PW-1:0]        nom_sr2_on,
    input  logic [PW-1:0]        nom_sr2_off,
    input  logic signed [MW-1:0] bal_mod,
    input  logic [7:0]           edge_cfg,
    input  logic [7:0]           dly_cfg,
    output logic [PW-1:0]        phase,
    output logic                 sr1_gate,
    output logic                 sr2_gate
);
    localparam int NGATE = NUM_EDGES / 2;
    localparam logic [PW-1:0] PER_MIN = PW'(2);

    typedef struct packed {
        logic [PW-1:0]                cnt;
        logic [PW-1:0]                per;
        logic [NUM_EDGES-1:0][PW-1:0] edg;
        logic [NGATE-1:0]             gate;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_EDGES-1:0][PW-1:0] nom_all, calc_edg, edg_n;
    logic [PW-1:0]                per_eff, cnt_n, per_n;
    logic [NGATE-1:0]             win;
    logic                         wrap;

    // exposed to the bound checker
    logic [PW-1:0]                per_cur;
    logic [NUM_EDGES-1:0][PW-1:0] edg_cur;

    assign nom_all[EDGE_SR1_ON]  = nom_sr1_on;
    assign nom_all[EDGE_SR1_OFF] = nom_sr1_off;
    assign nom_all[EDGE_SR2_ON]  = nom_sr2_on;
    assign nom_all[EDGE_SR2_OFF] = nom_sr2_off;

    assign per_eff = (period < PER_MIN) ? PER_MIN : period;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EDGES; gi++) begin : g_edge
            sr_edge_calc #(.PW(PW), .MW(MW)) u_calc (
                .nom     (nom_all[gi]),
                .per_eff (per_eff),
                .mod_val (bal_mod),
                .ctl     (ctl_of(edge_cfg, gi)),
                .dly     (dly_cfg[DLY_BITS-1:0]),
                .edge_t  (calc_edg[gi])
            );
        end
    endgenerate

    // period boundary: also taken straight out of reset (per_q == 0)
    assign wrap  = ({1'b0, st_q.cnt} + 1'b1) >= {1'b0, st_q.per};
    assign cnt_n = wrap ? '0 : st_q.cnt + 1'b1;
    assign per_n = wrap ? per_eff : st_q.per;
    assign edg_n = wrap ? calc_edg : st_q.edg;

    generate
        for (gi = 0; gi < NGATE; gi++) begin : g_win
            sr_gate_win #(.PW(PW)) u_win (
                .pos   (cnt_n),
                .t_on  (edg_n[2*gi]),
                .t_off (edg_n[2*gi+1]),
                .gate  (win[gi])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = cnt_n;
        st_d.per  = per_n;
        st_d.edg  = edg_n;
        st_d.gate = win;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.cnt;
    assign sr1_gate = st_q.gate[0];
    assign sr2_gate = st_q.gate[1];
    assign per_cur  = st_q.per;
    assign edg_cur  = st_q.edg;

endmodule

// File: rtl/sr_edge_mod_chk.sv
module sr_edge_mod_chk #(
    parameter int PW = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PW-1:0]        phase,
    input logic [PW-1:0]        per_cur,
    input logic [3:0][PW-1:0]   edg_cur,
    input logic                 sr1_gate,
    input logic                 sr2_gate
);
    logic live, mid;
    assign live = (per_cur != '0);
    assign mid  = live && (({1'b0, phase} + 1'b1) < {1'b0, per_cur});

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mid |=> phase == $past(phase) + 1'b1); // R1

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (phase < per_cur) && (per_cur >= PW'(2))); // R1

    AST_EDGE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (edg_cur[0] < per_cur) && (edg_cur[1] < per_cur)
              && (edg_cur[2] < per_cur) && (edg_cur[3] < per_cur)); // R8

    AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        mid |=> $stable(edg_cur) && $stable(per_cur)); // R9

    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (live && edg_cur[0] >= edg_cur[1]) |-> !sr1_gate); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !sr1_gate && !sr2_gate && (phase == '0)); // R10

endmodule

bind sr_edge_mod sr_edge_mod_chk #(.PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .per_cur  (per_cur),
    .edg_cur  (edg_cur),
    .sr1_gate (sr1_gate),
    .sr2_gate (sr2_gate)
);

// File: tb/sr_edge_mod_bench.sv
module sr_edge_mod_bench;

    localparam int PW = 10;
    localparam int MW = 8;

    typedef struct packed {
        logic [PW-1:0]        per;
        logic [PW-1:0]        n0;
        logic [PW-1:0]        n1;
        logic [PW-1:0]        n2;
        logic [PW-1:0]        n3;
        logic signed [MW-1:0] m;
        logic [7:0]           cfg;
        logic [7:0]           dly;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{10'd120, 10'd10, 10'd50, 10'd60, 10'd100,  8'sd20,  8'h00, 8'h00}, // R4
        '{10'd120, 10'd10, 10'd50, 10'd60, 10'd100,  8'sd20,  8'hAA, 8'h00}, // R5 later
        '{10'd120, 10'd10, 10'd50, 10'd60, 10'd100,  8'sd20,  8'hFF, 8'h00}, // R5 earlier
        '{10'd120, 10'd30, 10'd60, 10'd70, 10'd110,  8'sd25,  8'h80, 8'h00}, // R3 bits 7/6
        '{10'd120, 10'd30, 10'd60, 10'd70, 10'd110,  8'sd25,  8'h30, 8'h00}, // R3 bits 5/4
        '{10'd120, 10'd30, 10'd60, 10'd70, 10'd110,  8'sd25,  8'h0C, 8'h00}, // R3 bits 3/2
        '{10'd120, 10'd30, 10'd60, 10'd70, 10'd110,  8'sd25,  8'h02, 8'h00}, // R3 bits 1/0
        '{10'd120, 10'd40, 10'd80, 10'd50, 10'd90,   8'sd0,   8'h00, 8'h1E}, // R6
        '{10'd120, 10'd40, 10'd80, 10'd50, 10'd90,   8'sd0,   8'h00, 8'hC5}, // R7
        '{10'd60,  10'd40, 10'd20, 10'd10, 10'd59,  -8'sd50,  8'hAA, 8'h00}, // R2
        '{10'd100, 10'd70, 10'd90, 10'd80, 10'd99,   8'sd100, 8'h22, 8'h3F}  // R8
    };
    localparam string VTAG [NV] = '{"R4", "R5", "R5", "R3", "R3", "R3", "R3",
                                    "R6", "R7", "R2", "R8"};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [PW-1:0]        period = '0;
    logic [PW-1:0]        nom_sr1_on = '0, nom_sr1_off = '0, nom_sr2_on = '0, nom_sr2_off = '0;
    logic signed [MW-1:0] bal_mod = '0;
    logic [7:0]           edge_cfg = '0, dly_cfg = '0;
    logic [PW-1:0]        phase;
    logic                 sr1_gate, sr2_gate;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sr_edge_mod #(.PW(PW), .MW(MW)) u_sr_edge_mod (
        .clk, .rst_n, .period, .nom_sr1_on, .nom_sr1_off, .nom_sr2_on, .nom_sr2_off,
        .bal_mod, .edge_cfg, .dly_cfg, .phase, .sr1_gate, .sr2_gate
    );

    function automatic int eff_per(input vec_t v);
        return (v.per < 2) ? 2 : int'(v.per);
    endfunction

    // expected edge time from R3/R5/R6/R8
    function automatic int exp_edge(input vec_t v, input int idx);
        int nom, val, p;
        logic en, sg;
        nom = (idx == 0) ? int'(v.n0) : (idx == 1) ? int'(v.n1) :
              (idx == 2) ? int'(v.n2) : int'(v.n3);
        en  = v.cfg[7 - 2*idx];
        sg  = v.cfg[6 - 2*idx];
        p   = eff_per(v);
        val = nom - int'(v.dly[5:0]);
        if (en) val = sg ? val - int'(v.m) : val + int'(v.m);
        if (val < 0) val = 0;
        if (val > p - 1) val = p - 1;
        return val;
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        period      = v.per;
        nom_sr1_on  = v.n0;
        nom_sr1_off = v.n1;
        nom_sr2_on  = v.n2;
        nom_sr2_off = v.n3;
        bal_mod     = v.m;
        edge_cfg    = v.cfg;
        dly_cfg     = v.dly;
    endtask

    task automatic wait_start();
        do @(negedge clk); while (phase != '0);
    endtask

    // Called at a negedge with phase == 0; checks the whole period against v.
    // At position chg_at it drives nv (R9).
    task automatic check_period(input string tag, input vec_t v,
                                input int chg_at, input vec_t nv);
        int p, e0, e1, e2, e3;
        int bad_g, bad_p, first_k, act_g, exp_g;
        bit g1, g2;
        p  = eff_per(v);
        e0 = exp_edge(v, 0); e1 = exp_edge(v, 1);
        e2 = exp_edge(v, 2); e3 = exp_edge(v, 3);
        bad_g = 0; bad_p = 0; first_k = -1; act_g = 0; exp_g = 0;
        for (int k = 0; k < p; k++) begin
            if (k > 0) @(negedge clk);
            if (int'(phase) != k) bad_p++;
            g1 = (k >= e0) && (k < e1);
            g2 = (k >= e2) && (k < e3);
            if (sr1_gate !== g1 || sr2_gate !== g2) begin
                if (bad_g == 0) begin
                    first_k = k;
                    act_g = {sr2_gate, sr1_gate};
                    exp_g = {g2, g1};
                end
                bad_g++;
            end
            if (k == chg_at) drive(nv);
        end
        check(tag, bad_g == 0, $sformatf("gates{sr2,sr1} at phase %0d", first_k), act_g, exp_g);
        check("R1", bad_p == 0, "phase sequence mismatches", bad_p, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        vec_t a, b;
        drive(VECS[0]);
        // R10: reset state
        repeat (4) @(negedge clk);
        check("R10", phase == '0, "phase in reset", int'(phase), 0);
        check("R10", !sr1_gate && !sr2_gate, "gates in reset", {sr2_gate, sr1_gate}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", phase == '0, "first phase after release", int'(phase), 0);
        @(negedge clk);
        check("R10", phase == 10'd1, "second phase after release", int'(phase), 1);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            wait_start();
            check_period(VTAG[i], VECS[i], -1, VECS[i]);
        end

        // R9: change mid-period, old settings hold until the wrap
        a = VECS[1];
        b = VECS[2];
        b.dly = 8'h0A;
        drive(a);
        wait_start();
        check_period("R9", a, 37, b);
        @(negedge clk);
        check_period("R9", b, -1, b);

        // R1: period below minimum runs as 2
        a = VECS[0];
        a.per = 10'd1;
        a.n0 = 10'd0; a.n1 = 10'd1; a.n2 = 10'd1; a.n3 = 10'd1;
        drive(a);
        wait_start();
        check_period("R1", a, -1, a);
        @(negedge clk);
        check("R1", phase == '0, "wrap after 2 phases", int'(phase), 0);
        a.per = 10'd0;
        drive(a);
        wait_start();
        check_period("R1", a, -1, a);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule